// File: doc/BRIEF.md
# Transport Stream Packet Capture Engine

This block takes in fixed-length transport stream packets and lays them into a double-word-wide buffer that a DMA engine reads. Bytes arrive either on a byte-wide parallel port qualified by a valid strobe, or as a bit stream with its own bit clock. A configuration bit selects between the two. The block counts the bytes of each packet against a programmed length. After the last byte it appends an 8-byte timestamp, taken from a free-running counter, and pads the record with zeros so that it ends on a double-word boundary. Every record therefore starts on a double-word boundary and spans an even number of 32-bit words.

A byte-count threshold raises a one-cycle event. It is normally set equal to the packet length, so the event marks a packet that is complete in the buffer. When error filtering is enabled, a packet that had the error flag asserted on any of its bytes is discarded. The buffer write position is then rewound to where that packet began. A committed-pointer output tells the reader how far valid records extend. The buffer is read through a registered address/data port.

Top module: `ts_capture`

## Requirements
- R1: The packet length is the 24-bit value formed with `cfg_size_hi` as bits 23:12 and `cfg_size_lo` as bits 11:0. Legal lengths are 8 or more. Each run of that many accepted bytes forms one packet.
- R2: `pkt_evt` is high for exactly one cycle after the second rising edge following the edge that samples the byte whose position in its packet (counting from 1) equals `cfg_thresh`. It is suppressed when filtering is on and an error has been seen on any byte of that packet up to and including that byte. A threshold of 0, or one larger than the packet length, gives no event.
- R3: Packet byte n (counting from 0) is stored in double-word record_start + n/8, at bits 8*(n%8)+7 : 8*(n%8).
- R4: The 8 bytes that follow a packet hold a 64-bit timestamp, least significant byte first. The value equals the number of non-reset clock edges up to and including the edge that samples the packet's first byte.
- R5: When `cfg_serial` is 0, bytes are taken from `par_data` on every edge where `par_valid` is 1, and the serial pins are ignored. When it is 1, `ser_data` is sampled on each clock edge at which `ser_clk` is 1 after having been 0 at the previous edge. Eight such bits, most significant first, make one byte, and `par_valid` and `par_data` are ignored.
- R6: After a kept packet of length P, `commit_ptr` advances by ceil((P+8)/8) modulo the buffer depth. It changes in the same cycle as the event of a threshold equal to P, and at no other time.
- R7: With `cfg_err_filter` at 1, a packet with `pkt_err` high on any of its bytes produces no event and leaves `commit_ptr` unchanged. The next packet is written from the same start position. With the filter at 0, such a packet is kept like any other.
- R8: Bytes between the end of the timestamp and the next double-word boundary read as zero. Each record starts at the double-word index given by `commit_ptr` before it.
- R9: While `rst` is high at a clock edge, `pkt_evt` and `commit_ptr` are set to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_lo | input | 12 | Packet length, low 12 bits |
| cfg_size_hi | input | 12 | Packet length, high 12 bits |
| cfg_thresh | input | 24 | Byte-count threshold for the event |
| cfg_serial | input | 1 | 0: parallel input, 1: serial input |
| cfg_err_filter | input | 1 | Discard packets that carry an error flag |
| par_data | input | 8 | Parallel byte |
| par_valid | input | 1 | Parallel byte strobe |
| ser_clk | input | 1 | Serial bit clock, sampled by `clk` |
| ser_data | input | 1 | Serial data bit |
| pkt_err | input | 1 | Error mark, taken with each accepted byte |
| rd_addr | input | AW | Buffer read address (double words) |
| rd_data | output | 64 | Buffer read data, one cycle after `rd_addr` |
| commit_ptr | output | AW | Double-word index after the last kept record |
| pkt_evt | output | 1 | Threshold event pulse |

## Verification
At a packet boundary with back-to-back parallel input, two functions share one cycle. The second trailer double word (timestamp tail and padding) is written, and the first byte of the next packet is accepted and samples a new timestamp. The bench provokes this by holding `par_valid` high across several packets of lengths 20 and 13, which are not multiples of 8. It judges the result by comparing `pkt_evt` and `commit_ptr` on every clock against a byte-queue reference model. It then reads back every committed double word, so a trailer word overwritten or displaced by the next packet's bytes shows up as a data mismatch.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int SIZE_W = 24;
  localparam int WORD_W = 64;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef struct packed {
    logic              vld;
    logic              err;
    logic [BYTE_W-1:0] dat;
  } byte_beat_t;
endpackage

// File: rtl/ts_cap_front.sv
// Input selection and bit-serial deserializer; emits one registered byte beat.
module ts_cap_front
  import ts_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_mode,
  input  logic [BYTE_W-1:0] par_data,
  input  logic              par_valid,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              pkt_err,
  output byte_beat_t        beat
);
  localparam int BC_W = $clog2(BYTE_W);

  logic              ser_prev;
  logic [BC_W-1:0]   bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic              rise;

  assign rise = ser_clk & ~ser_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_prev <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      beat     <= '0;
    end else begin
      ser_prev <= ser_clk;
      beat.vld <= 1'b0;
      if (!ser_mode) begin
        bit_cnt <= '0;
        if (par_valid) beat <= '{vld: 1'b1, err: pkt_err, dat: par_data};
      end else if (rise) begin
        shreg   <= {shreg[BYTE_W-3:0], ser_data};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BC_W'(BYTE_W - 1))
          beat <= '{vld: 1'b1, err: pkt_err, dat: {shreg, ser_data}};
      end
    end
  end

  // R5
  ser_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && beat.vld) |=> !beat.vld);
endmodule

// File: rtl/ts_cap_pack.sv
// Packet counter, double-word packer, timestamp trailer and pointer control.
module ts_cap_pack
  import ts_cap_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] pkt_size,
  input  logic [SIZE_W-1:0] thresh,
  input  logic              err_filter,
  input  byte_beat_t        beat,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [AW-1:0]     commit_ptr,
  output logic              pkt_evt
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic [SIZE_W-1:0] cnt, cnt_n;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] acc, acc_n, ts_free, ts_cap, ts_use;
  logic [WORD_W-1:0] word_a, word_b, word_b_n;
  logic [AW-1:0]     wr_ptr;
  logic              bad, bad_n, first, last, drop, hit, hit_d, pend_b;
  logic [LANE_W+2:0] k8;
  logic [LANE_W+3:0] rsh;

  always_comb begin
    first    = (cnt == '0);
    cnt_n    = cnt + 1'b1;
    ts_use   = first ? ts_free : ts_cap;
    acc_n    = acc | (WORD_W'(beat.dat) << {lane, 3'b000});
    bad_n    = (bad & ~first) | beat.err;
    last     = beat.vld && (cnt_n == pkt_size);
    drop     = last && err_filter && bad_n;
    hit      = beat.vld && (cnt_n == thresh) && !(err_filter && bad_n);
    k8       = {lane + 1'b1, 3'b000};
    rsh      = (LANE_W+4)'(WORD_W) - {1'b0, k8};
    word_a   = (lane == LAST_LANE) ? acc_n : (acc_n | (ts_use << k8));
    word_b_n = (lane == LAST_LANE) ? ts_use : (ts_use >> rsh);

    wr_addr = wr_ptr;
    wr_en   = 1'b0;
    wr_data = word_b;
    if (pend_b) begin
      wr_en = 1'b1;
    end else if (last && !drop) begin
      wr_en   = 1'b1;
      wr_data = word_a;
    end else if (beat.vld && !last && lane == LAST_LANE) begin
      wr_en   = 1'b1;
      wr_data = acc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      lane       <= '0;
      acc        <= '0;
      bad        <= 1'b0;
      ts_free    <= '0;
      ts_cap     <= '0;
      word_b     <= '0;
      wr_ptr     <= '0;
      commit_ptr <= '0;
      pend_b     <= 1'b0;
      hit_d      <= 1'b0;
      pkt_evt    <= 1'b0;
    end else begin
      ts_free <= ts_free + 1'b1;
      hit_d   <= hit;
      pkt_evt <= hit_d;
      if (pend_b) begin
        pend_b     <= 1'b0;
        wr_ptr     <= wr_ptr + 1'b1;
        commit_ptr <= wr_ptr + 1'b1;
      end
      if (beat.vld) begin
        if (first) ts_cap <= ts_free;
        if (last) begin
          cnt  <= '0;
          lane <= '0;
          acc  <= '0;
          bad  <= 1'b0;
          if (drop) begin
            wr_ptr <= commit_ptr;
          end else begin
            wr_ptr <= wr_ptr + 1'b1;
            pend_b <= 1'b1;
            word_b <= word_b_n;
          end
        end else begin
          cnt  <= cnt_n;
          lane <= lane + 1'b1;
          bad  <= bad_n;
          if (lane == LAST_LANE) begin
            acc    <= '0;
            wr_ptr <= wr_ptr + 1'b1;
          end else begin
            acc <= acc_n;
          end
        end
      end
    end
  end

  // R1
  wr_port_free_chk: assert property (@(posedge clk) disable iff (rst)
    pend_b |-> !(beat.vld && (lane == LAST_LANE || cnt_n == pkt_size)));

  // R2
  evt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_evt |=> !pkt_evt);

  // R6
  commit_src_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_ptr != $past(commit_ptr)) |-> $past(pend_b));

  // R7
  drop_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    drop |=> (wr_ptr == commit_ptr));
endmodule

// File: rtl/ts_cap_ram.sv
// Simple dual-port buffer: synchronous write, registered read.
module ts_cap_ram #(
  parameter int AW = 6,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ts_capture.sv
module ts_capture
  import ts_cap_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       cfg_size_lo,
  input  logic [11:0]       cfg_size_hi,
  input  logic [SIZE_W-1:0] cfg_thresh,
  input  logic              cfg_serial,
  input  logic              cfg_err_filter,
  input  logic [BYTE_W-1:0] par_data,
  input  logic              par_valid,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              pkt_err,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [AW-1:0]     commit_ptr,
  output logic              pkt_evt
);
  byte_beat_t        beat;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [WORD_W-1:0] wr_data;

  ts_cap_front u_front (
    .clk      (clk),
    .rst      (rst),
    .ser_mode (cfg_serial),
    .par_data (par_data),
    .par_valid(par_valid),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .pkt_err  (pkt_err),
    .beat     (beat)
  );

  ts_cap_pack #(.AW(AW)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .pkt_size  ({cfg_size_hi, cfg_size_lo}),
    .thresh    (cfg_thresh),
    .err_filter(cfg_err_filter),
    .beat      (beat),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .commit_ptr(commit_ptr),
    .pkt_evt   (pkt_evt)
  );

  ts_cap_ram #(.AW(AW), .DW(WORD_W)) u_ram (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: tb/sim_ts_capture.sv
module sim_ts_capture;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] cfg_size_lo = '0, cfg_size_hi = '0;
  logic [23:0] cfg_thresh = '0;
  logic cfg_serial = 1'b0, cfg_err_filter = 1'b0;
  logic [7:0] par_data = '0;
  logic par_valid = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, pkt_err = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [63:0] rd_data;
  logic [AW-1:0] commit_ptr;
  logic pkt_evt;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] dseed = 8'h11;

  always #(CLK_P/2) clk = ~clk;

  ts_capture #(.AW(AW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [63:0] exp_mem [int];
  bit vset [int];
  logic [7:0] pq [$];
  int mcnt = 0, mbits = 0, mwr = 0, c0 = -1, c1 = -1, c2 = -1;
  bit mprev = 0, mbad = 0, e0 = 0, e1 = 0, e2 = 0;
  logic [7:0] msh = '0;
  longint unsigned tcount = 0, mts = 0;
  logic [AW-1:0] expc = '0;

  always @(posedge clk) begin
    bit got, er, hit;
    logic [7:0] d;
    int plen, nc;
    logic [63:0] w;
    got = 0; er = 0; hit = 0; d = '0; nc = -1;
    plen = int'({cfg_size_hi, cfg_size_lo});
    if (rst) begin
      tcount = 0; mcnt = 0; mbits = 0; mwr = 0; mprev = 0; mbad = 0;
      e0 = 0; e1 = 0; e2 = 0; c0 = -1; c1 = -1; c2 = -1; expc = '0;
      pq.delete();
    end else begin
      tcount++;
      if (cfg_serial) begin
        if (ser_clk && !mprev) begin
          msh = {msh[6:0], ser_data};
          mbits++;
          if (mbits == 8) begin got = 1; d = msh; er = pkt_err; mbits = 0; end
        end
      end else begin
        mbits = 0;
        if (par_valid) begin got = 1; d = par_data; er = pkt_err; end
      end
      mprev = ser_clk;
      if (got) begin
        if (mcnt == 0) begin pq.delete(); mbad = 0; mts = tcount; end
        mcnt++;
        pq.push_back(d);
        mbad = mbad | er;
        if (mcnt == int'(cfg_thresh) && !(cfg_err_filter && mbad)) hit = 1;
        if (mcnt == plen) begin
          if (!(cfg_err_filter && mbad)) begin
            for (int i = 0; i < 8; i++) pq.push_back(mts[8*i +: 8]);
            while (pq.size() % 8 != 0) pq.push_back(8'h00);
            for (int k = 0; k < pq.size() / 8; k++) begin
              w = '0;
              for (int j = 0; j < 8; j++) w[8*j +: 8] = pq[8*k + j];
              exp_mem[mwr] = w;
              vset[mwr] = 1;
              mwr = (mwr + 1) % DEPTH;
            end
            nc = mwr;
          end
          mcnt = 0;
        end
      end
      e2 = e1; e1 = e0; e0 = hit;
      c2 = c1; c1 = c0; c0 = nc;
      if (c2 >= 0) expc = c2[AW-1:0];
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(pkt_evt === e2, "R2 event pulse", 64'(pkt_evt), 64'(e2));
      chk(commit_ptr === expc, "R6 commit pointer", 64'(commit_ptr), 64'(expc));
    end
  end

  task automatic set_cfg(input int plen, input int thr, input bit ser, input bit filt);
    @(negedge clk);
    {cfg_size_hi, cfg_size_lo} = plen[23:0];
    cfg_thresh = thr[23:0];
    cfg_serial = ser;
    cfg_err_filter = filt;
    vset.delete();
  endtask

  task automatic send_par(input int n, input int errpos, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      par_valid = 1'b1; par_data = dseed; dseed = dseed + 8'd37;
      pkt_err = (i == errpos);
      if (gap) begin @(negedge clk); par_valid = 1'b0; pkt_err = 1'b0; end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    par_valid = 1'b0; pkt_err = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_ser(input int n, input int errpos);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        @(negedge clk);
        ser_data = dseed[b]; ser_clk = 1'b1;
        pkt_err = (b == 0) && (i == errpos);
        @(negedge clk);
        ser_clk = 1'b0; pkt_err = 1'b0;
      end
      dseed = dseed + 8'd53;
    end
  endtask

  task automatic readback(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      if (vset.exists(i)) begin
        @(negedge clk);
        rd_addr = i[AW-1:0];
        @(negedge clk);
        chk(rd_data === exp_mem[i], tag, rd_data, exp_mem[i]);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(commit_ptr === '0 && pkt_evt === 1'b0, "R9 reset state", 64'({commit_ptr, pkt_evt}), 64'd0);
    rst = 1'b0;

    // back-to-back parallel, length not a multiple of 8
    set_cfg(20, 20, 0, 0);
    send_par(20, -1, 0); send_par(20, -1, 0); send_par(20, -1, 0);
    idle(6);
    readback("R3 R4 R8 parallel back-to-back len 20");

    // length a multiple of 8, gapped input
    set_cfg(16, 16, 0, 0);
    send_par(16, -1, 1); send_par(16, -1, 1);
    idle(6);
    readback("R8 gapped len 16");

    // threshold below packet length
    set_cfg(13, 5, 0, 0);
    send_par(13, -1, 0); send_par(13, -1, 0);
    idle(6);
    readback("R2 R3 mid-packet threshold len 13");

    // threshold zero: no event
    set_cfg(9, 0, 0, 0);
    send_par(9, -1, 0);
    idle(6);
    readback("R2 threshold zero");

    // error filtering on
    set_cfg(12, 12, 0, 1);
    send_par(12, 3, 0);
    send_par(12, -1, 0);
    send_par(12, 11, 1);
    send_par(12, -1, 0);
    idle(6);
    readback("R7 filtered packets rewound");

    // error filtering off keeps errored packet
    set_cfg(12, 12, 0, 0);
    send_par(12, 0, 0);
    idle(6);
    readback("R7 filter off keeps packet");

    // serial mode with parallel noise
    set_cfg(9, 9, 1, 0);
    @(negedge clk); par_valid = 1'b1; par_data = 8'hA5;
    send_ser(9, -1);
    send_ser(9, -1);
    idle(8);
    readback("R5 serial MSB first");

    // serial with filter: dropped
    set_cfg(9, 9, 1, 1);
    send_ser(9, 4);
    send_ser(9, -1);
    idle(8);
    readback("R5 R7 serial filtered");

    // long packet using high size field
    set_cfg(4100, 4100, 0, 0);
    send_par(4100, -1, 0);
    idle(6);
    readback("R1 high size field len 4100");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule